// File: doc/BRIEF.md
# Banked Control Register File

This block holds the control state of a small 32-bit processor core: a status word whose top bit picks the stack mode, a condition flag, a byte saved from the status on trap entry, a second-level saved status, two saved return addresses, a pair of banked stack pointers and two general scratch words. Software reaches it through a combinational indexed read port and an indexed write port that commits on the clock edge. A separate 8-bit port gives direct access to the status byte together with the condition flag.

The working stack pointer lives in the core's general register file, outside this block. The block sees its current value on `gsp_value` and may overwrite it through `gsp_we`/`gsp_wdata` on the same edge as a control write. The stack-pointer index that matches the current mode is an alias for that external register. The other index reaches a banked copy inside the block. When a status write flips the mode bit, the live pointer is saved into the bank of the mode being left and reloaded from the bank of the mode being entered, all on one edge. A small combinational translator maps debugger register numbers onto control indices.

Top module: `ctrl_bank_regfile`

## Requirements
- R1: After a synchronous reset every index reads zero, the 8-bit status port reads zero, the stack mode is 0 and `gsp_we` is low.
- R2: Reading index 0 returns zero in bits 31:16. Bits 15:8 hold the saved status byte ANDed with 0xC1, bits 7:6 hold live status bits 7:6, and bit 0 holds the condition flag. All other bits read zero.
- R3: Writing index 0 loads wr_data[15:8] into the saved status byte, wr_data[7:0] into the live status and wr_data[0] into the condition flag. If bit 7, the stack mode, is unchanged, `gsp_we` stays low.
- R4: A write to index 0 that changes the stack mode drives `gsp_we` in that cycle. Going from 1 to 0 saves `gsp_value` into the user bank and loads the live pointer from the interrupt bank. Going from 0 to 1 saves `gsp_value` into the interrupt bank and loads the live pointer from the user bank.
- R5: Index 2, the interrupt stack pointer, reads `gsp_value` and writes through `gsp_we` while the mode is 0. While the mode is 1 it reads and writes the interrupt bank.
- R6: Index 3, the user stack pointer, reads `gsp_value` and writes through `gsp_we` while the mode is 1. While the mode is 0 it reads and writes the user bank.
- R7: Indices 6 and 14, the two saved return addresses, store all 32 written bits and read back with bit 0 forced to zero.
- R8: Index 8, the second-level saved status, stores wr_data[7:0] and reads back that byte ANDed with 0xC1, zero-extended.
- R9: Index 1 reads and writes only the condition flag in bit 0. Indices 4 and 5 are plain 32-bit storage.
- R10: Indices 7, 9 to 13 and 15 read zero. Writes to them change no state and do not drive `gsp_we`.
- R11: `stat8_rd` returns live status bits 7:1 with the condition flag in bit 0. A `stat8_we` write with `wr_en` low sets the live status and the condition flag and never banks or moves the stack pointer. While `wr_en` is high, `stat8_we` is ignored.
- R12: When a read and a write target the same index in one cycle, the read returns the value from before the write.
- R13: Debugger numbers 16 to 23 set `dbg_hit` and map to indices 0, 1, 2, 3, 6, 8, 14, 5 in that order. Any other number clears `dbg_hit` and gives index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx | input | IDX_W | Control index to read |
| rd_data | output | DATA_W | Read data, combinational from rd_idx |
| wr_en | input | 1 | Indexed write enable |
| wr_idx | input | IDX_W | Control index to write |
| wr_data | input | DATA_W | Write data |
| gsp_value | input | DATA_W | Current working stack pointer from the register file |
| gsp_we | output | 1 | Overwrite the working stack pointer on this edge |
| gsp_wdata | output | DATA_W | New working stack pointer value |
| stat8_rd | output | 8 | Status byte with the condition flag in bit 0 |
| stat8_we | input | 1 | Byte status write enable |
| stat8_wdata | input | 8 | Byte status write data |
| dbg_num | input | DBG_W | Debugger register number |
| dbg_idx | output | IDX_W | Translated control index |
| dbg_hit | output | 1 | Debugger number is mapped |

## Verification
The bench builds the block with its defaults: DATA_W 32, IDX_W 4, DBG_W 6 and DBG_BASE 16. A 4-bit index gives exactly sixteen slots, so every unmapped index can be written and read back one by one. A 6-bit debugger number lets the bench sweep all 64 values, covering the mapped window and every miss on both sides of it. The bench keeps its own copy of the external stack pointer, updated from `gsp_we`, so that stack swaps in both directions can be observed through that copy and through the two stack-pointer indices.

// File: rtl/ctrlrf_pkg.sv
package ctrlrf_pkg;

    // Control index map (decoded by neighbours, so fixed)
    localparam int unsigned CR_STAT  = 0;
    localparam int unsigned CR_COND  = 1;
    localparam int unsigned CR_ISP   = 2;
    localparam int unsigned CR_USP   = 3;
    localparam int unsigned CR_SCR0  = 4;
    localparam int unsigned CR_SCR1  = 5;
    localparam int unsigned CR_SPC   = 6;
    localparam int unsigned CR_STAT2 = 8;
    localparam int unsigned CR_SPC2  = 14;

    localparam int unsigned DBG_SLOTS = 8;
    localparam int unsigned SCR_N     = 2;
    localparam int unsigned MODE_BIT  = 7;

    localparam logic [7:0] SAVE_MASK = 8'hC1;
    localparam logic [7:0] LIVE_MASK = 8'hC0;

    typedef enum logic [3:0] {
        T_STAT, T_COND, T_ISP, T_USP, T_SCR0, T_SCR1,
        T_SPC, T_STAT2, T_SPC2, T_NONE
    } cr_sel_e;

    typedef struct packed {
        logic [7:0] saved;
        logic [7:0] live;
        logic       cond;
    } stat_t;

    function automatic cr_sel_e idx_sel(input int unsigned i);
        case (i)
            CR_STAT:  return T_STAT;
            CR_COND:  return T_COND;
            CR_ISP:   return T_ISP;
            CR_USP:   return T_USP;
            CR_SCR0:  return T_SCR0;
            CR_SCR1:  return T_SCR1;
            CR_SPC:   return T_SPC;
            CR_STAT2: return T_STAT2;
            CR_SPC2:  return T_SPC2;
            default:  return T_NONE;
        endcase
    endfunction

    function automatic int unsigned sel_idx(input cr_sel_e s);
        case (s)
            T_STAT:  return CR_STAT;
            T_COND:  return CR_COND;
            T_ISP:   return CR_ISP;
            T_USP:   return CR_USP;
            T_SCR0:  return CR_SCR0;
            T_SCR1:  return CR_SCR1;
            T_SPC:   return CR_SPC;
            T_STAT2: return CR_STAT2;
            T_SPC2:  return CR_SPC2;
            default: return 0;
        endcase
    endfunction

    // Debugger slot order: status, cond, int sp, user sp, pc save, status2, pc save2, scratch1
    function automatic cr_sel_e dbg_slot_sel(input logic [2:0] slot);
        case (slot)
            3'd0:    return T_STAT;
            3'd1:    return T_COND;
            3'd2:    return T_ISP;
            3'd3:    return T_USP;
            3'd4:    return T_SPC;
            3'd5:    return T_STAT2;
            3'd6:    return T_SPC2;
            default: return T_SCR1;
        endcase
    endfunction

    function automatic cr_sel_e scr_sel(input int unsigned g);
        return (g == 0) ? T_SCR0 : T_SCR1;
    endfunction

endpackage

// File: rtl/ctrlrf_decode.sv
module ctrlrf_decode
    import ctrlrf_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    output cr_sel_e          sel
);

    always_comb sel = idx_sel(32'(idx));

endmodule

// File: rtl/ctrlrf_dbgmap.sv
module ctrlrf_dbgmap
    import ctrlrf_pkg::*;
#(
    parameter int DBG_W    = 6,
    parameter int DBG_BASE = 16,
    parameter int IDX_W    = 4
) (
    input  logic [DBG_W-1:0] dbg_num,
    output logic [IDX_W-1:0] dbg_idx,
    output logic             dbg_hit
);

    logic [DBG_W-1:0] off;

    always_comb begin
        off     = dbg_num - DBG_W'(DBG_BASE);
        dbg_hit = (dbg_num >= DBG_W'(DBG_BASE)) && (off < DBG_W'(DBG_SLOTS));
        dbg_idx = dbg_hit ? IDX_W'(sel_idx(dbg_slot_sel(off[2:0]))) : '0;
    end

    // R13: a miss always yields index 0
    always_comb begin
        a_r13_miss_zero: assert (dbg_hit || dbg_idx == '0);
    end

endmodule

// File: rtl/ctrlrf_spbank.sv
module ctrlrf_spbank #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode,
    input  logic              wr_stat,
    input  logic              new_mode,
    input  logic              wr_isp,
    input  logic              wr_usp,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] gsp_value,
    output logic [DATA_W-1:0] isp_view,
    output logic [DATA_W-1:0] usp_view,
    output logic              gsp_we,
    output logic [DATA_W-1:0] gsp_wdata
);

    logic [DATA_W-1:0] isp_q;
    logic [DATA_W-1:0] usp_q;
    logic              swap;

    assign swap = wr_stat && (new_mode != mode);

    always_comb begin
        gsp_we    = 1'b0;
        gsp_wdata = wr_data;
        if (swap) begin
            gsp_we    = 1'b1;
            gsp_wdata = mode ? isp_q : usp_q;
        end else if (wr_isp && !mode) begin
            gsp_we = 1'b1;
        end else if (wr_usp && mode) begin
            gsp_we = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isp_q <= '0;
            usp_q <= '0;
        end else begin
            if (swap && mode)  usp_q <= gsp_value;
            if (swap && !mode) isp_q <= gsp_value;
            if (wr_isp && mode)  isp_q <= wr_data;
            if (wr_usp && !mode) usp_q <= wr_data;
        end
    end

    assign isp_view = mode ? isp_q : gsp_value;
    assign usp_view = mode ? gsp_value : usp_q;

    // R4: leaving mode 1 banks the live pointer as the user copy
    a_r4_save_user: assert property (@(posedge clk) disable iff (rst)
        (swap && mode) |=> (usp_q == $past(gsp_value)));
    // R4: leaving mode 0 banks the live pointer as the interrupt copy
    a_r4_save_int: assert property (@(posedge clk) disable iff (rst)
        (swap && !mode) |=> (isp_q == $past(gsp_value)));
    // R4: a mode change always reloads the live pointer
    a_r4_reload: assert property (@(posedge clk) disable iff (rst)
        swap |-> gsp_we);
    // R5: in mode 1 the interrupt index writes the bank, not the live pointer
    a_r5_isp_bank: assert property (@(posedge clk) disable iff (rst)
        (wr_isp && mode) |=> (isp_q == $past(wr_data)));
    // R6: in mode 0 the user index writes the bank, not the live pointer
    a_r6_usp_bank: assert property (@(posedge clk) disable iff (rst)
        (wr_usp && !mode) |=> (usp_q == $past(wr_data)));

endmodule

// File: rtl/ctrl_bank_regfile.sv
module ctrl_bank_regfile
    import ctrlrf_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 4,
    parameter int DBG_W    = 6,
    parameter int DBG_BASE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] gsp_value,
    output logic              gsp_we,
    output logic [DATA_W-1:0] gsp_wdata,
    output logic [7:0]        stat8_rd,
    input  logic              stat8_we,
    input  logic [7:0]        stat8_wdata,
    input  logic [DBG_W-1:0]  dbg_num,
    output logic [IDX_W-1:0]  dbg_idx,
    output logic              dbg_hit
);

    localparam int HI_W = DATA_W - 16;

    cr_sel_e           rsel;
    cr_sel_e           wsel;
    stat_t             stat_q;
    logic [7:0]        stat2_q;
    logic [DATA_W-1:0] spc_q;
    logic [DATA_W-1:0] spc2_q;
    logic [DATA_W-1:0] scr_q [SCR_N];
    logic [DATA_W-1:0] isp_view;
    logic [DATA_W-1:0] usp_view;
    logic              mode;

    assign mode = stat_q.live[MODE_BIT];

    ctrlrf_decode #(.IDX_W(IDX_W)) u_rdec (.idx(rd_idx), .sel(rsel));
    ctrlrf_decode #(.IDX_W(IDX_W)) u_wdec (.idx(wr_idx), .sel(wsel));

    ctrlrf_spbank #(.DATA_W(DATA_W)) u_spbank (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .wr_stat   (wr_en && wsel == T_STAT),
        .new_mode  (wr_data[MODE_BIT]),
        .wr_isp    (wr_en && wsel == T_ISP),
        .wr_usp    (wr_en && wsel == T_USP),
        .wr_data   (wr_data),
        .gsp_value (gsp_value),
        .isp_view  (isp_view),
        .usp_view  (usp_view),
        .gsp_we    (gsp_we),
        .gsp_wdata (gsp_wdata)
    );

    ctrlrf_dbgmap #(.DBG_W(DBG_W), .DBG_BASE(DBG_BASE), .IDX_W(IDX_W)) u_dbgmap (
        .dbg_num (dbg_num),
        .dbg_idx (dbg_idx),
        .dbg_hit (dbg_hit)
    );

    // Status, condition flag and second-level status
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= '0;
            stat2_q <= '0;
        end else if (wr_en) begin
            case (wsel)
                T_STAT: begin
                    stat_q.saved <= wr_data[15:8];
                    stat_q.live  <= wr_data[7:0];
                    stat_q.cond  <= wr_data[0];
                end
                T_COND:  stat_q.cond <= wr_data[0];
                T_STAT2: stat2_q     <= wr_data[7:0];
                default: ;
            endcase
        end else if (stat8_we) begin
            stat_q.live <= stat8_wdata;
            stat_q.cond <= stat8_wdata[0];
        end
    end

    // Saved return addresses
    always_ff @(posedge clk) begin
        if (rst) begin
            spc_q  <= '0;
            spc2_q <= '0;
        end else if (wr_en) begin
            if (wsel == T_SPC)  spc_q  <= wr_data;
            if (wsel == T_SPC2) spc2_q <= wr_data;
        end
    end

    // Scratch words
    for (genvar g = 0; g < SCR_N; g++) begin : g_scr
        always_ff @(posedge clk) begin
            if (rst)
                scr_q[g] <= '0;
            else if (wr_en && wsel == scr_sel(g))
                scr_q[g] <= wr_data;
        end
    end

    always_comb begin
        case (rsel)
            T_STAT:  rd_data = {{HI_W{1'b0}}, stat_q.saved & SAVE_MASK,
                                (stat_q.live & LIVE_MASK) | {7'b0, stat_q.cond}};
            T_COND:  rd_data = {{(DATA_W-1){1'b0}}, stat_q.cond};
            T_ISP:   rd_data = isp_view;
            T_USP:   rd_data = usp_view;
            T_SCR0:  rd_data = scr_q[0];
            T_SCR1:  rd_data = scr_q[1];
            T_SPC:   rd_data = {spc_q[DATA_W-1:1], 1'b0};
            T_STAT2: rd_data = {{(DATA_W-8){1'b0}}, stat2_q & SAVE_MASK};
            T_SPC2:  rd_data = {spc2_q[DATA_W-1:1], 1'b0};
            default: rd_data = '0;
        endcase
    end

    assign stat8_rd = {stat_q.live[7:1], stat_q.cond};

    // R1: reset leaves status cleared and mode 0
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (stat_q == '0 && !mode));
    // R3: status write moves bit 0 into the condition flag
    a_r3_cond_follow: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wsel == T_STAT) |=> (stat_q.cond == $past(wr_data[0])));
    // R10: writes to unmapped indices leave state untouched
    a_r10_no_effect: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wsel == T_NONE) |=>
            (stat_q == $past(stat_q) && stat2_q == $past(stat2_q)
             && spc_q == $past(spc_q) && spc2_q == $past(spc2_q)));
    // R10: unmapped writes never reach the live stack pointer
    a_r10_no_live_sp: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wsel == T_NONE) |-> !gsp_we);
    // R11: byte status writes never move the stack pointer
    a_r11_byte_no_swap: assert property (@(posedge clk) disable iff (rst)
        (stat8_we && !wr_en) |-> !gsp_we);

endmodule

// File: tb/ctrl_bank_regfile_test.sv
module ctrl_bank_regfile_test;

    localparam int DATA_W = 32;
    localparam int IDX_W  = 4;
    localparam int DBG_W  = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] gsp_reg = '0;
    logic              gsp_we;
    logic [DATA_W-1:0] gsp_wdata;
    logic [7:0]        stat8_rd;
    logic              stat8_we = 1'b0;
    logic [7:0]        stat8_wdata = '0;
    logic [DBG_W-1:0]  dbg_num = '0;
    logic [IDX_W-1:0]  dbg_idx;
    logic              dbg_hit;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    // External register file copy of the working stack pointer
    always @(posedge clk) if (gsp_we) gsp_reg <= gsp_wdata;

    ctrl_bank_regfile uut (
        .clk(clk), .rst(rst),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .gsp_value(gsp_reg), .gsp_we(gsp_we), .gsp_wdata(gsp_wdata),
        .stat8_rd(stat8_rd), .stat8_we(stat8_we), .stat8_wdata(stat8_wdata),
        .dbg_num(dbg_num), .dbg_idx(dbg_idx), .dbg_hit(dbg_hit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int idx, input logic [31:0] exp);
        rd_idx = IDX_W'(idx);
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic set_gsp(input logic [31:0] v);
        @(negedge clk);
        gsp_reg = v;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 16; i++) rd_chk("R1", i, 32'h0);
        check("R1", {24'h0, stat8_rd}, 32'h0);
        check("R1", {31'h0, gsp_we}, 32'h0);
    endtask

    task automatic t_status;
        set_gsp(32'hAAAA_0000);
        wr(0, 32'h0000_C1FF);                 // mode 0 -> 1
        rd_chk("R2", 0, 32'h0000_C1C1);
        check("R3", {24'h0, stat8_rd}, 32'hFF);
        check("R4", gsp_reg, 32'h0);          // reloaded from user bank
        rd_chk("R5", 2, 32'hAAAA_0000);       // interrupt bank got old live
        rd_chk("R6", 3, 32'h0);
        set_gsp(32'h1234_5678);
        wr(0, 32'h0000_3E02);                 // mode 1 -> 0
        rd_chk("R2", 0, 32'h0);
        check("R3", {24'h0, stat8_rd}, 32'h02);
        check("R4", gsp_reg, 32'hAAAA_0000);
        rd_chk("R6", 3, 32'h1234_5678);
        rd_chk("R5", 2, 32'hAAAA_0000);
        wr(0, 32'h0000_FF41);                 // mode stays 0
        check("R3", gsp_reg, 32'hAAAA_0000);
        rd_chk("R2", 0, 32'h0000_C141);
        rd_chk("R9", 1, 32'h1);
    endtask

    task automatic t_sp_steer;
        wr(0, 32'h0);
        wr(2, 32'h5555_0000);
        check("R5", gsp_reg, 32'h5555_0000);
        wr(3, 32'h7777_0000);
        check("R6", gsp_reg, 32'h5555_0000);
        rd_chk("R6", 3, 32'h7777_0000);
        wr(0, 32'h0000_0080);                 // to mode 1
        check("R4", gsp_reg, 32'h7777_0000);
        wr(3, 32'h9999_0000);
        check("R6", gsp_reg, 32'h9999_0000);
        wr(2, 32'h4444_0000);
        check("R5", gsp_reg, 32'h9999_0000);
        rd_chk("R5", 2, 32'h4444_0000);
        wr(0, 32'h0);                          // back to mode 0
        check("R4", gsp_reg, 32'h4444_0000);
        rd_chk("R6", 3, 32'h9999_0000);
    endtask

    task automatic t_pc;
        wr(6, 32'hFFFF_FFFF);
        rd_chk("R7", 6, 32'hFFFF_FFFE);
        wr(14, 32'h8000_0003);
        rd_chk("R7", 14, 32'h8000_0002);
    endtask

    task automatic t_stat2;
        wr(8, 32'hFFFF_FF7F);
        rd_chk("R8", 8, 32'h0000_0041);
    endtask

    task automatic t_cond_scratch;
        wr(1, 32'hFFFF_FFFE);
        rd_chk("R9", 1, 32'h0);
        wr(1, 32'h0000_0003);
        rd_chk("R9", 1, 32'h1);
        rd_chk("R9", 0, 32'h1);
        wr(4, 32'hDEAD_BEEF);
        wr(5, 32'h0BAD_F00D);
        rd_chk("R9", 4, 32'hDEAD_BEEF);
        rd_chk("R9", 5, 32'h0BAD_F00D);
    endtask

    task automatic t_unmapped;
        int bad [7] = '{7, 9, 10, 11, 12, 13, 15};
        for (int k = 0; k < 7; k++) begin
            wr(bad[k], 32'hFFFF_FFFF);
            rd_chk("R10", bad[k], 32'h0);
        end
        rd_chk("R10", 0, 32'h1);
        rd_chk("R10", 6, 32'hFFFF_FFFE);
        rd_chk("R10", 8, 32'h41);
        rd_chk("R10", 4, 32'hDEAD_BEEF);
        check("R10", gsp_reg, 32'h4444_0000);
    endtask

    task automatic t_byte;
        @(negedge clk);
        stat8_we = 1'b1; stat8_wdata = 8'h81;
        @(negedge clk);
        stat8_we = 1'b0;
        check("R11", {24'h0, stat8_rd}, 32'h81);
        check("R11", gsp_reg, 32'h4444_0000);  // no swap
        rd_chk("R11", 3, 32'h4444_0000);        // mode 1 aliases live
        @(negedge clk);
        stat8_we = 1'b1; stat8_wdata = 8'h00;
        wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h1111_2222;
        @(negedge clk);
        stat8_we = 1'b0; wr_en = 1'b0;
        check("R11", {24'h0, stat8_rd}, 32'h81);
        @(negedge clk);
        stat8_we = 1'b1; stat8_wdata = 8'h00;
        @(negedge clk);
        stat8_we = 1'b0;
        check("R11", {24'h0, stat8_rd}, 32'h00);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd4; wr_data = 32'hCAFE_F00D;
        rd_idx = 4'd4;
        #1;
        check("R12", rd_data, 32'hDEAD_BEEF);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R12", rd_data, 32'hCAFE_F00D);
    endtask

    task automatic t_dbg;
        int map [8] = '{0, 1, 2, 3, 6, 8, 14, 5};
        for (int n = 0; n < 64; n++) begin
            dbg_num = DBG_W'(n);
            #1;
            if (n >= 16 && n < 24) begin
                check("R13", {31'h0, dbg_hit}, 32'h1);
                check("R13", {28'h0, dbg_idx}, 32'(map[n-16]));
            end else begin
                check("R13", {31'h0, dbg_hit}, 32'h0);
                check("R13", {28'h0, dbg_idx}, 32'h0);
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_status();
        t_sp_steer();
        t_pc();
        t_stat2();
        t_cond_scratch();
        t_unmapped();
        t_byte();
        t_same_cycle();
        t_dbg();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule